// File: doc/BRIEF.md
# Virtual-to-Physical Address Remapping Table

This block sits between the accelerator's internal bus masters and the port that leads out to shared external DRAM. Every read-address and write-address request is looked up in a small table of programmable address ranges. A request that hits an entry leaves with its address rewritten to a physical DRAM address. The host can therefore hand a raw virtual pointer to the accelerator, and the accelerator dereferences it without any software conversion. Traffic that stays inside the accelerator's own window uses a different port and never reaches this block.

Each entry holds a valid bit, an inclusive lower and upper virtual bound, and a physical offset. Two configuration write ports can rewrite the entries at any time while traffic keeps flowing: one belongs to the host processor and one to the accelerator's cores. A request that matches no entry is not passed on. The block answers it itself with an error response, and its address is recorded for software in a sticky miss register. The read-data, write-data and write-response channels pass straight through, apart from the error responses the block inserts for misses.

Top module: `addr_remap_table`

## Requirements
- R1: A read request whose address A falls in valid entry k leaves on the master read-address port with address A - lower(k) + offset(k), the same ID and the same length, one cycle after it is accepted.
- R2: A write request is translated by the same rule as R1 and leaves on the master write-address port one cycle after it is accepted.
- R3: Both bounds of an entry are inclusive: the lower and upper bound addresses match, while the addresses one below the lower bound and one above the upper bound do not match that entry.
- R4: When several valid entries match, the one with the lowest index translates the request. An entry whose valid bit is 0 never matches.
- R5: A read that misses is never forwarded. It receives exactly len+1 read beats with response code 2'b10 (slave error), its own ID, and last set on the final beat only.
- R6: A write that misses is never forwarded. Its write-data beats are accepted and dropped up to and including the last beat, and it then receives one write response with code 2'b10 and its own ID.
- R7: A miss on either channel sets the miss flag and loads the miss address register with the untranslated address. The flag stays set until it is cleared.
- R8: A configuration write with address bit 5 set clears the miss flag, from either port. If a miss occurs in the same cycle, the flag stays set.
- R9: Configuration address layout: bit 5 = control, bits 4:2 = entry index, bits 1:0 = field (0 lower bound, 1 upper bound, 2 offset, 3 valid in data bit 0). Both ports may write. When both ports write the same entry in one cycle, only the host write takes effect, while writes to different entries both take effect.
- R10: A change to an entry applies to every request accepted after the write, without a reset.
- R11: Downstream read beats and write responses reach the upstream side unchanged, and write data for a forwarded write reaches the master port unchanged.
- R12: After reset no entry is valid, the miss flag is clear and no output valid is asserted, so the first request of any kind misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcfg_we | input | 1 | Host configuration write strobe |
| hcfg_addr | input | 6 | Host configuration register address |
| hcfg_wdata | input | 32 | Host configuration write data |
| ccfg_we | input | 1 | Core configuration write strobe |
| ccfg_addr | input | 6 | Core configuration register address |
| ccfg_wdata | input | 32 | Core configuration write data |
| s_ar_valid | input | 1 | Upstream read request valid |
| s_ar_ready | output | 1 | Upstream read request ready |
| s_ar_addr | input | 32 | Upstream read virtual address |
| s_ar_id | input | 4 | Upstream read ID |
| s_ar_len | input | 8 | Upstream read burst length minus one |
| m_ar_valid | output | 1 | Translated read request valid |
| m_ar_ready | input | 1 | Translated read request ready |
| m_ar_addr | output | 32 | Translated read physical address |
| m_ar_id | output | 4 | Translated read ID |
| m_ar_len | output | 8 | Translated read length |
| s_r_valid | output | 1 | Upstream read beat valid |
| s_r_ready | input | 1 | Upstream read beat ready |
| s_r_data | output | 32 | Upstream read data |
| s_r_resp | output | 2 | Upstream read response code |
| s_r_id | output | 4 | Upstream read beat ID |
| s_r_last | output | 1 | Upstream final read beat |
| m_r_valid | input | 1 | Downstream read beat valid |
| m_r_ready | output | 1 | Downstream read beat ready |
| m_r_data | input | 32 | Downstream read data |
| m_r_resp | input | 2 | Downstream read response |
| m_r_id | input | 4 | Downstream read beat ID |
| m_r_last | input | 1 | Downstream final read beat |
| s_aw_valid | input | 1 | Upstream write request valid |
| s_aw_ready | output | 1 | Upstream write request ready |
| s_aw_addr | input | 32 | Upstream write virtual address |
| s_aw_id | input | 4 | Upstream write ID |
| s_aw_len | input | 8 | Upstream write length minus one |
| m_aw_valid | output | 1 | Translated write request valid |
| m_aw_ready | input | 1 | Translated write request ready |
| m_aw_addr | output | 32 | Translated write physical address |
| m_aw_id | output | 4 | Translated write ID |
| m_aw_len | output | 8 | Translated write length |
| s_w_valid | input | 1 | Upstream write beat valid |
| s_w_ready | output | 1 | Upstream write beat ready |
| s_w_data | input | 32 | Upstream write data |
| s_w_strb | input | 4 | Upstream byte enables |
| s_w_last | input | 1 | Upstream final write beat |
| m_w_valid | output | 1 | Downstream write beat valid |
| m_w_ready | input | 1 | Downstream write beat ready |
| m_w_data | output | 32 | Downstream write data |
| m_w_strb | output | 4 | Downstream byte enables |
| m_w_last | output | 1 | Downstream final write beat |
| s_b_valid | output | 1 | Upstream write response valid |
| s_b_ready | input | 1 | Upstream write response ready |
| s_b_resp | output | 2 | Upstream write response code |
| s_b_id | output | 4 | Upstream write response ID |
| m_b_valid | input | 1 | Downstream write response valid |
| m_b_ready | output | 1 | Downstream write response ready |
| m_b_resp | input | 2 | Downstream write response code |
| m_b_id | input | 4 | Downstream write response ID |
| miss_flag | output | 1 | Sticky translation miss flag |
| miss_addr | output | 32 | Virtual address of the latest miss |

## Verification
The holding properties assume that the downstream read beats and write responses obey the valid/ready rule, so that a presented beat stays valid until it is taken. The bench's slave model drives such beats only for one cycle while ready is held high, and it always accepts translated requests at once. The write-data checks assume that write beats of a burst follow its address request. The bench drives each burst's data only after the matching address was accepted, and it waits for the error response of a missed write before it starts the next write. Configuration writes are one-cycle strobes issued between requests, except in the same-cycle cases that are under test.

// File: rtl/remap_pkg.sv
// Shared types for the address remapping table.
// Assumes a fixed 32-bit address space for both virtual and physical sides.
package remap_pkg;
    localparam int ADDR_W = 32;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    // Field selector inside one entry's register group
    typedef enum logic [1:0] {
        FLD_LOWER = 2'd0,
        FLD_UPPER = 2'd1,
        FLD_OFFS  = 2'd2,
        FLD_VALID = 2'd3
    } field_e;

    // One translation range; bounds are inclusive
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] lower;
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] offs;
    } entry_t;
endpackage

// File: rtl/remap_entry_table.sv
// Storage for the translation entries with two configuration write ports.
// Address layout: {control, index, field}. Control writes clear the miss flag.
// Assumes N_ENT >= 2. Host port wins when both ports hit the same entry.
module remap_entry_table
    import remap_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int CFG_AW = IDX_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_we,
    input  logic [CFG_AW-1:0]        h_addr,
    input  logic [ADDR_W-1:0]        h_wdata,
    input  logic                     c_we,
    input  logic [CFG_AW-1:0]        c_addr,
    input  logic [ADDR_W-1:0]        c_wdata,
    output entry_t [N_ENT-1:0]       tbl,
    output logic                     clr
);
    // Clear request from either port's control region
    assign clr = (h_we && h_addr[CFG_AW-1]) || (c_we && c_addr[CFG_AW-1]);

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic              h_sel;
        logic              c_sel;
        logic [1:0]        fld;
        logic [ADDR_W-1:0] wd;

        assign h_sel = h_we && !h_addr[CFG_AW-1] && (h_addr[CFG_AW-2:2] == IDX_W'(e));
        assign c_sel = c_we && !c_addr[CFG_AW-1] && (c_addr[CFG_AW-2:2] == IDX_W'(e));

        // Pick the write source for this entry, host first
        always_comb begin
            if (h_sel) begin
                fld = h_addr[1:0];
                wd  = h_wdata;
            end else begin
                fld = c_addr[1:0];
                wd  = c_wdata;
            end
        end

        // Update the selected field of this entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[e] <= '0;
            end else if (h_sel || c_sel) begin
                case (field_e'(fld))
                    FLD_LOWER: tbl[e].lower <= wd;
                    FLD_UPPER: tbl[e].upper <= wd;
                    FLD_OFFS:  tbl[e].offs  <= wd;
                    default:   tbl[e].vld   <= wd[0];
                endcase
            end
        end
    end
endmodule

// File: rtl/remap_chan_stage.sv
// Lookup plus one register stage for an address channel.
// The lookup uses the table at accept time; a hit goes to the master side,
// a miss goes to the error side. 'gate' can hold off acceptance.
module remap_chan_stage
    import remap_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int ID_W  = 4,
    parameter int LEN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  entry_t [N_ENT-1:0] tbl,
    input  logic               gate,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [ID_W-1:0]    in_id,
    input  logic [LEN_W-1:0]   in_len,
    output logic               acc,
    output logic               acc_hit,
    output logic               fwd_valid,
    input  logic               fwd_ready,
    output logic               err_valid,
    input  logic               err_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [ID_W-1:0]    out_id,
    output logic [LEN_W-1:0]   out_len
);
    logic              full_q;
    logic              hit_q;
    logic              drain;
    logic [ADDR_W-1:0] xlat;

    // Priority match: scan downward so the lowest index is applied last
    always_comb begin
        acc_hit = 1'b0;
        xlat    = in_addr;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (tbl[i].vld && in_addr >= tbl[i].lower && in_addr <= tbl[i].upper) begin
                acc_hit = 1'b1;
                xlat    = in_addr - tbl[i].lower + tbl[i].offs;
            end
        end
    end

    assign drain     = full_q && (hit_q ? fwd_ready : err_ready);
    assign in_ready  = (!full_q || drain) && gate;
    assign acc       = in_valid && in_ready;
    assign fwd_valid = full_q && hit_q;
    assign err_valid = full_q && !hit_q;

    // Register stage holding one translated request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 1'b0;
            hit_q    <= 1'b0;
            out_addr <= '0;
            out_id   <= '0;
            out_len  <= '0;
        end else if (acc) begin
            full_q   <= 1'b1;
            hit_q    <= acc_hit;
            out_addr <= xlat;
            out_id   <= in_id;
            out_len  <= in_len;
        end else if (drain) begin
            full_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/remap_rd_err.sv
// Generates the error read burst for a missed read: len+1 beats, last on the final one.
// Takes one miss at a time.
module remap_rd_err #(
    parameter int ID_W  = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ID_W-1:0]  in_id,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ID_W-1:0]  out_id,
    output logic             out_last
);
    logic             busy_q;
    logic [LEN_W-1:0] left_q;

    assign in_ready  = !busy_q;
    assign out_valid = busy_q;
    assign out_last  = (left_q == '0);

    // Count down the remaining beats of the error burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            out_id <= '0;
        end else if (in_valid && in_ready) begin
            busy_q <= 1'b1;
            left_q <= in_len;
            out_id <= in_id;
        end else if (out_valid && out_ready) begin
            if (out_last) busy_q <= 1'b0;
            else          left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/remap_resp_merge.sv
// Merges downstream responses (side A) with locally generated errors (side B).
// A is preferred when idle; the choice is held while a beat waits or a burst is open.
module remap_resp_merge #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    output logic          a_ready,
    input  logic [PW-1:0] a_pay,
    input  logic          a_last,
    input  logic          b_valid,
    output logic          b_ready,
    input  logic [PW-1:0] b_pay,
    input  logic          b_last,
    output logic          y_valid,
    input  logic          y_ready,
    output logic [PW-1:0] y_pay,
    output logic          y_last
);
    logic lock_q;
    logic own_b_q;
    logic use_b;

    assign use_b   = lock_q ? own_b_q : !a_valid;
    assign y_valid = use_b ? b_valid : a_valid;
    assign y_pay   = use_b ? b_pay : a_pay;
    assign y_last  = use_b ? b_last : a_last;
    assign a_ready = y_ready && !use_b;
    assign b_ready = y_ready && use_b;

    // Keep the owner until the final beat is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            own_b_q <= 1'b0;
        end else begin
            lock_q  <= y_valid && !(y_ready && y_last);
            own_b_q <= use_b;
        end
    end
endmodule

// File: rtl/remap_wr_route.sv
// Steers write-data bursts in address order: forward for hits, sink for misses.
// A sunk burst ends with one error write response. Assumes DEPTH is a power of two.
module remap_wr_route #(
    parameter int ID_W  = 4,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            push_drop,
    input  logic [ID_W-1:0] push_id,
    output logic            full,
    input  logic            s_w_valid,
    output logic            s_w_ready,
    input  logic            s_w_last,
    output logic            m_w_valid,
    input  logic            m_w_ready,
    output logic            eb_valid,
    input  logic            eb_ready,
    output logic [ID_W-1:0] eb_id
);
    logic [DEPTH-1:0]           drop_q;
    logic [DEPTH-1:0][ID_W-1:0] id_q;
    logic [PTR_W-1:0]           wp_q;
    logic [PTR_W-1:0]           rp_q;
    logic [PTR_W:0]             cnt_q;
    logic                       empty;
    logic                       pop;
    logic                       head_drop;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
    assign head_drop = drop_q[rp_q];

    // Route the current write beat according to the oldest pending burst
    always_comb begin
        m_w_valid = 1'b0;
        s_w_ready = 1'b0;
        if (!empty) begin
            if (head_drop) begin
                s_w_ready = !eb_valid;
            end else begin
                m_w_valid = s_w_valid;
                s_w_ready = m_w_ready;
            end
        end
    end

    assign pop = s_w_valid && s_w_ready && s_w_last;

    // Routing queue pointers and contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            drop_q <= '0;
            id_q   <= '0;
        end else begin
            if (push) begin
                drop_q[wp_q] <= push_drop;
                id_q[wp_q]   <= push_id;
                wp_q         <= wp_q + 1'b1;
            end
            if (pop) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    // Error write response for a sunk burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eb_valid <= 1'b0;
            eb_id    <= '0;
        end else if (pop && head_drop) begin
            eb_valid <= 1'b1;
            eb_id    <= id_q[rp_q];
        end else if (eb_ready) begin
            eb_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/addr_remap_table.sv
// Address remapping table on the path to external shared memory.
// Translates read and write addresses through programmable ranges, answers
// misses with slave errors and records them in a sticky register.
// Assumes upstream write data follows its address request.
module addr_remap_table
    import remap_pkg::*;
#(
    parameter int N_ENT    = 8,
    parameter int ID_W     = 4,
    parameter int LEN_W    = 8,
    parameter int DATA_W   = 32,
    parameter int WQ_DEPTH = 4,
    localparam int CFG_AW  = $clog2(N_ENT) + 3,
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hcfg_we,
    input  logic [CFG_AW-1:0] hcfg_addr,
    input  logic [ADDR_W-1:0] hcfg_wdata,
    input  logic              ccfg_we,
    input  logic [CFG_AW-1:0] ccfg_addr,
    input  logic [ADDR_W-1:0] ccfg_wdata,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [LEN_W-1:0]  s_ar_len,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [ID_W-1:0]   m_ar_id,
    output logic [LEN_W-1:0]  m_ar_len,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic [ID_W-1:0]   s_r_id,
    output logic              s_r_last,
    input  logic              m_r_valid,
    output logic              m_r_ready,
    input  logic [DATA_W-1:0] m_r_data,
    input  logic [1:0]        m_r_resp,
    input  logic [ID_W-1:0]   m_r_id,
    input  logic              m_r_last,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [LEN_W-1:0]  s_aw_len,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [ID_W-1:0]   m_aw_id,
    output logic [LEN_W-1:0]  m_aw_len,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic [STRB_W-1:0] s_w_strb,
    input  logic              s_w_last,
    output logic              m_w_valid,
    input  logic              m_w_ready,
    output logic [DATA_W-1:0] m_w_data,
    output logic [STRB_W-1:0] m_w_strb,
    output logic              m_w_last,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [1:0]        s_b_resp,
    output logic [ID_W-1:0]   s_b_id,
    input  logic              m_b_valid,
    output logic              m_b_ready,
    input  logic [1:0]        m_b_resp,
    input  logic [ID_W-1:0]   m_b_id,
    output logic              miss_flag,
    output logic [ADDR_W-1:0] miss_addr
);
    localparam int RPW = DATA_W + 2 + ID_W;
    localparam int BPW = 2 + ID_W;

    entry_t [N_ENT-1:0] tbl;
    logic               tbl_clr;
    logic               ar_acc, ar_hit, aw_acc, aw_hit;
    logic               rm_valid, rm_ready, we_valid;
    logic [ADDR_W-1:0]  rm_addr, we_addr;
    logic [ID_W-1:0]    rm_id, we_id, re_id, eb_id;
    logic [LEN_W-1:0]   rm_len, we_len;
    logic               re_valid, re_ready, re_last;
    logic               eb_valid, eb_ready;
    logic               wq_full;
    logic               b_last_unused;

    remap_entry_table #(.N_ENT(N_ENT)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .h_we(hcfg_we), .h_addr(hcfg_addr), .h_wdata(hcfg_wdata),
        .c_we(ccfg_we), .c_addr(ccfg_addr), .c_wdata(ccfg_wdata),
        .tbl(tbl), .clr(tbl_clr)
    );

    remap_chan_stage #(.N_ENT(N_ENT), .ID_W(ID_W), .LEN_W(LEN_W)) u_ar (
        .clk(clk), .rst_n(rst_n), .tbl(tbl), .gate(1'b1),
        .in_valid(s_ar_valid), .in_ready(s_ar_ready),
        .in_addr(s_ar_addr), .in_id(s_ar_id), .in_len(s_ar_len),
        .acc(ar_acc), .acc_hit(ar_hit),
        .fwd_valid(m_ar_valid), .fwd_ready(m_ar_ready),
        .err_valid(rm_valid), .err_ready(rm_ready),
        .out_addr(rm_addr), .out_id(rm_id), .out_len(rm_len)
    );
    assign m_ar_addr = rm_addr;
    assign m_ar_id   = rm_id;
    assign m_ar_len  = rm_len;

    remap_rd_err #(.ID_W(ID_W), .LEN_W(LEN_W)) u_rerr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rm_valid), .in_ready(rm_ready), .in_id(rm_id), .in_len(rm_len),
        .out_valid(re_valid), .out_ready(re_ready), .out_id(re_id), .out_last(re_last)
    );

    remap_resp_merge #(.PW(RPW)) u_rmerge (
        .clk(clk), .rst_n(rst_n),
        .a_valid(m_r_valid), .a_ready(m_r_ready),
        .a_pay({m_r_data, m_r_resp, m_r_id}), .a_last(m_r_last),
        .b_valid(re_valid), .b_ready(re_ready),
        .b_pay({{DATA_W{1'b0}}, RESP_SLVERR, re_id}), .b_last(re_last),
        .y_valid(s_r_valid), .y_ready(s_r_ready),
        .y_pay({s_r_data, s_r_resp, s_r_id}), .y_last(s_r_last)
    );

    remap_chan_stage #(.N_ENT(N_ENT), .ID_W(ID_W), .LEN_W(LEN_W)) u_aw (
        .clk(clk), .rst_n(rst_n), .tbl(tbl), .gate(!wq_full),
        .in_valid(s_aw_valid), .in_ready(s_aw_ready),
        .in_addr(s_aw_addr), .in_id(s_aw_id), .in_len(s_aw_len),
        .acc(aw_acc), .acc_hit(aw_hit),
        .fwd_valid(m_aw_valid), .fwd_ready(m_aw_ready),
        .err_valid(we_valid), .err_ready(1'b1),
        .out_addr(we_addr), .out_id(we_id), .out_len(we_len)
    );
    assign m_aw_addr = we_addr;
    assign m_aw_id   = we_id;
    assign m_aw_len  = we_len;

    remap_wr_route #(.ID_W(ID_W), .DEPTH(WQ_DEPTH)) u_wroute (
        .clk(clk), .rst_n(rst_n),
        .push(aw_acc), .push_drop(!aw_hit), .push_id(s_aw_id), .full(wq_full),
        .s_w_valid(s_w_valid), .s_w_ready(s_w_ready), .s_w_last(s_w_last),
        .m_w_valid(m_w_valid), .m_w_ready(m_w_ready),
        .eb_valid(eb_valid), .eb_ready(eb_ready), .eb_id(eb_id)
    );
    assign m_w_data = s_w_data;
    assign m_w_strb = s_w_strb;
    assign m_w_last = s_w_last;

    remap_resp_merge #(.PW(BPW)) u_bmerge (
        .clk(clk), .rst_n(rst_n),
        .a_valid(m_b_valid), .a_ready(m_b_ready),
        .a_pay({m_b_resp, m_b_id}), .a_last(1'b1),
        .b_valid(eb_valid), .b_ready(eb_ready),
        .b_pay({RESP_SLVERR, eb_id}), .b_last(1'b1),
        .y_valid(s_b_valid), .y_ready(s_b_ready),
        .y_pay({s_b_resp, s_b_id}), .y_last(b_last_unused)
    );

    // Sticky miss record; a new miss outranks a clear, reads outrank writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_flag <= 1'b0;
            miss_addr <= '0;
        end else if ((ar_acc && !ar_hit) || (aw_acc && !aw_hit)) begin
            miss_flag <= 1'b1;
            miss_addr <= (ar_acc && !ar_hit) ? s_ar_addr : s_aw_addr;
        end else if (tbl_clr) begin
            miss_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/remap_table_checker.sv
// Protocol and miss-register properties for addr_remap_table, bound below.
module remap_table_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        m_ar_valid,
    input logic        m_ar_ready,
    input logic [31:0] m_ar_addr,
    input logic        m_aw_valid,
    input logic        m_aw_ready,
    input logic [31:0] m_aw_addr,
    input logic        s_r_valid,
    input logic        s_r_ready,
    input logic [1:0]  s_r_resp,
    input logic        s_r_last,
    input logic        s_w_valid,
    input logic        m_w_valid,
    input logic        s_b_valid,
    input logic        s_b_ready,
    input logic [1:0]  s_b_resp,
    input logic        miss_flag,
    input logic        clr,
    input logic        ar_acc,
    input logic        aw_acc
);
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_ar_valid && !m_ar_ready |=> m_ar_valid && $stable(m_ar_addr)); // R1
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_aw_valid && !m_aw_ready |=> m_aw_valid && $stable(m_aw_addr)); // R2
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_r_valid && !s_r_ready |=> s_r_valid && $stable(s_r_resp) && $stable(s_r_last)); // R5
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_b_valid && !s_b_ready |=> s_b_valid && $stable(s_b_resp)); // R6
    AST_W_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        m_w_valid |-> s_w_valid); // R6
    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        miss_flag && !clr |=> miss_flag); // R7
    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !ar_acc && !aw_acc |=> !miss_flag); // R8
endmodule

bind addr_remap_table remap_table_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr),
    .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr),
    .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_resp(s_r_resp), .s_r_last(s_r_last),
    .s_w_valid(s_w_valid), .m_w_valid(m_w_valid),
    .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_resp(s_b_resp),
    .miss_flag(miss_flag), .clr(tbl_clr), .ar_acc(ar_acc), .aw_acc(aw_acc)
);

// File: tb/addr_remap_table_test.sv
`timescale 1ns/1ps
module addr_remap_table_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        hcfg_we = 0, ccfg_we = 0;
    logic [5:0]  hcfg_addr = 0, ccfg_addr = 0;
    logic [31:0] hcfg_wdata = 0, ccfg_wdata = 0;
    logic        s_ar_valid = 0, s_ar_ready;
    logic [31:0] s_ar_addr = 0;
    logic [3:0]  s_ar_id = 0;
    logic [7:0]  s_ar_len = 0;
    logic        m_ar_valid, m_ar_ready = 1;
    logic [31:0] m_ar_addr;
    logic [3:0]  m_ar_id;
    logic [7:0]  m_ar_len;
    logic        s_r_valid, s_r_ready = 1, s_r_last;
    logic [31:0] s_r_data;
    logic [1:0]  s_r_resp;
    logic [3:0]  s_r_id;
    logic        m_r_valid = 0, m_r_ready, m_r_last = 0;
    logic [31:0] m_r_data = 0;
    logic [1:0]  m_r_resp = 0;
    logic [3:0]  m_r_id = 0;
    logic        s_aw_valid = 0, s_aw_ready;
    logic [31:0] s_aw_addr = 0;
    logic [3:0]  s_aw_id = 0;
    logic [7:0]  s_aw_len = 0;
    logic        m_aw_valid, m_aw_ready = 1;
    logic [31:0] m_aw_addr;
    logic [3:0]  m_aw_id;
    logic [7:0]  m_aw_len;
    logic        s_w_valid = 0, s_w_ready, s_w_last = 0;
    logic [31:0] s_w_data = 0;
    logic [3:0]  s_w_strb = 4'hF;
    logic        m_w_valid, m_w_ready = 1, m_w_last;
    logic [31:0] m_w_data;
    logic [3:0]  m_w_strb;
    logic        s_b_valid, s_b_ready = 1;
    logic [1:0]  s_b_resp;
    logic [3:0]  s_b_id;
    logic        m_b_valid = 0, m_b_ready;
    logic [1:0]  m_b_resp = 0;
    logic [3:0]  m_b_id = 0;
    logic        miss_flag;
    logic [31:0] miss_addr;

    addr_remap_table uut (.*);

    int checks = 0;
    int errors = 0;

    // Bench-side copy of what software programmed
    logic [31:0] mlo [8];
    logic [31:0] mhi [8];
    logic [31:0] moff[8];
    logic        mvld[8];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected translation: {hit, address}, lowest valid index first
    function automatic logic [32:0] ref_xlat(input logic [31:0] a);
        for (int i = 0; i < 8; i++)
            if (mvld[i] && a >= mlo[i] && a <= mhi[i]) return {1'b1, a - mlo[i] + moff[i]};
        return {1'b0, a};
    endfunction

    task automatic cfg(input bit host, input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        if (host) begin hcfg_we = 1; hcfg_addr = {1'b0, 3'(idx), 2'(fld)}; hcfg_wdata = d; end
        else      begin ccfg_we = 1; ccfg_addr = {1'b0, 3'(idx), 2'(fld)}; ccfg_wdata = d; end
        @(negedge clk);
        hcfg_we = 0; ccfg_we = 0;
        case (fld)
            0: mlo[idx] = d;
            1: mhi[idx] = d;
            2: moff[idx] = d;
            default: mvld[idx] = d[0];
        endcase
    endtask

    task automatic set_entry(input bit host, input int idx, input logic [31:0] lo,
                             input logic [31:0] hi, input logic [31:0] off, input logic v);
        cfg(host, idx, 0, lo);
        cfg(host, idx, 1, hi);
        cfg(host, idx, 2, off);
        cfg(host, idx, 3, {31'd0, v});
    endtask

    task automatic clear_miss(input bit host);
        @(negedge clk);
        if (host) begin hcfg_we = 1; hcfg_addr = 6'h20; end
        else      begin ccfg_we = 1; ccfg_addr = 6'h20; end
        @(negedge clk);
        hcfg_we = 0; ccfg_we = 0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [3:0] id, input logic [7:0] len, input string req);
        logic [32:0] e;
        logic ok;
        int beats;
        e = ref_xlat(a);
        @(negedge clk);
        s_ar_valid = 1; s_ar_addr = a; s_ar_id = id; s_ar_len = len;
        do begin ok = s_ar_ready; @(negedge clk); end while (!ok);
        s_ar_valid = 0;
        if (e[32]) begin
            chk(m_ar_valid && m_ar_addr == e[31:0] && m_ar_id == id && m_ar_len == len, req,
                {m_ar_valid, m_ar_id, m_ar_len, m_ar_addr}, {1'b1, id, len, e[31:0]});
        end else begin
            chk(!m_ar_valid, {req, " R5 not forwarded"}, m_ar_valid, 0);
            chk(miss_flag && miss_addr == a, "R7 read miss record", {miss_flag, miss_addr}, {1'b1, a});
            beats = 0;
            for (int t = 0; t < 300; t++) begin
                @(negedge clk);
                if (s_r_valid) begin
                    beats++;
                    chk(s_r_resp == 2'b10 && s_r_id == id && s_r_last == (beats == int'(len) + 1),
                        "R5 error beat", {s_r_resp, s_r_id, s_r_last}, {2'b10, id, beats == int'(len) + 1});
                    if (s_r_last) break;
                end
            end
            chk(beats == int'(len) + 1, "R5 beat count", beats, int'(len) + 1);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [3:0] id, input logic [7:0] len, input string req);
        logic [32:0] e;
        logic ok;
        e = ref_xlat(a);
        @(negedge clk);
        s_aw_valid = 1; s_aw_addr = a; s_aw_id = id; s_aw_len = len;
        do begin ok = s_aw_ready; @(negedge clk); end while (!ok);
        s_aw_valid = 0;
        if (e[32])
            chk(m_aw_valid && m_aw_addr == e[31:0] && m_aw_id == id && m_aw_len == len, req,
                {m_aw_valid, m_aw_id, m_aw_len, m_aw_addr}, {1'b1, id, len, e[31:0]});
        else begin
            chk(!m_aw_valid, {req, " R6 not forwarded"}, m_aw_valid, 0);
            chk(miss_flag && miss_addr == a, "R7 write miss record", {miss_flag, miss_addr}, {1'b1, a});
        end
        for (int b = 0; b <= int'(len); b++) begin
            s_w_valid = 1; s_w_data = a ^ 32'(b * 7); s_w_last = (b == int'(len));
            #1;
            if (e[32])
                chk(m_w_valid && s_w_ready && m_w_data == s_w_data && m_w_last == s_w_last,
                    "R11 write data pass", {m_w_valid, s_w_ready, m_w_data}, {2'b11, s_w_data});
            else
                chk(!m_w_valid && s_w_ready, "R6 write data sunk", {m_w_valid, s_w_ready}, 2'b01);
            @(negedge clk);
        end
        s_w_valid = 0; s_w_last = 0;
        if (e[32]) begin
            m_b_valid = 1; m_b_id = id; m_b_resp = 2'b00;
            #1;
            chk(s_b_valid && s_b_id == id && s_b_resp == 2'b00, "R11 write response pass",
                {s_b_valid, s_b_id, s_b_resp}, {1'b1, id, 2'b00});
            @(negedge clk);
            m_b_valid = 0;
        end else begin
            ok = 0;
            for (int t = 0; t < 10 && !ok; t++) begin
                if (s_b_valid) begin
                    ok = 1;
                    chk(s_b_resp == 2'b10 && s_b_id == id, "R6 error response",
                        {s_b_resp, s_b_id}, {2'b10, id});
                end
                @(negedge clk);
            end
            chk(ok, "R6 error response present", ok, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mlo[i] = 0; mhi[i] = 0; moff[i] = 0; mvld[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: idle outputs and empty table
        chk(!miss_flag && !m_ar_valid && !m_aw_valid && !s_r_valid && !s_b_valid, "R12 reset state",
            {miss_flag, m_ar_valid, m_aw_valid, s_r_valid, s_b_valid}, 0);
        rd(32'h1000_0000, 4'h1, 8'd1, "R12 empty table read");
        clear_miss(1'b1);
        chk(!miss_flag, "R8 host clear", miss_flag, 0);

        // R9: entries alternate between the two configuration ports; entry 7 stays invalid
        for (int i = 0; i < 8; i++)
            set_entry(i % 2 == 0, i, 32'h1000_0000 + 32'(i) * 32'h0040_0000,
                      32'h1000_0000 + 32'(i) * 32'h0040_0000 + 32'h0001_FFFF,
                      32'h8000_0000 + 32'(i) * 32'h0123_4000, i != 7);

        // R1 R3 R4 R5: sweep around each entry's bounds on the read channel
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lo;
            lo = 32'h1000_0000 + 32'(i) * 32'h0040_0000;
            rd(lo - 1, 4'(i), 8'(i % 3), "R3 below lower");
            rd(lo, 4'(i), 8'(i % 3), "R1 R3 lower bound");
            rd(lo + 32'h1234, 4'(i + 1), 8'd0, "R1 inside");
            rd(lo + 32'h0001_FFFF, 4'(i + 2), 8'd2, "R3 upper bound");
            rd(lo + 32'h0002_0000, 4'(i), 8'd1, "R3 above upper");
        end
        chk(miss_flag, "R7 flag sticky across hits", miss_flag, 1);
        clear_miss(1'b0);
        chk(!miss_flag, "R8 core clear", miss_flag, 0);

        // R2 R6: write channel, hits and misses
        for (int i = 0; i < 8; i++) begin
            logic [31:0] lo;
            lo = 32'h1000_0000 + 32'(i) * 32'h0040_0000;
            wr(lo + 32'h40, 4'(i), 8'(i % 4), "R2 write hit");
            wr(lo + 32'h0002_0000, 4'(i + 3), 8'(i % 3), "R2 write miss");
        end

        // R4: overlap resolved by lowest index, invalid entry skipped
        set_entry(1'b1, 5, 32'h1000_0000, 32'h1000_FFFF, 32'hC000_0000, 1'b1);
        rd(32'h1000_0100, 4'h2, 8'd0, "R4 lowest index wins");
        cfg(1'b0, 0, 3, 32'd0);
        rd(32'h1000_0100, 4'h3, 8'd0, "R4 invalid entry skipped");

        // R10: reprogram an offset while running
        cfg(1'b0, 1, 2, 32'h4444_0000);
        rd(32'h1040_0010, 4'h4, 8'd0, "R10 new offset applies");
        wr(32'h1040_0020, 4'h5, 8'd1, "R10 new offset on write");

        // R9: same-entry collision, host wins; different entries both land
        @(negedge clk);
        hcfg_we = 1; hcfg_addr = {1'b0, 3'd3, 2'd2}; hcfg_wdata = 32'hAAAA_0000;
        ccfg_we = 1; ccfg_addr = {1'b0, 3'd3, 2'd2}; ccfg_wdata = 32'h5555_0000;
        @(negedge clk);
        hcfg_addr = {1'b0, 3'd4, 2'd2}; hcfg_wdata = 32'h1111_0000;
        ccfg_addr = {1'b0, 3'd6, 2'd2}; ccfg_wdata = 32'h2222_0000;
        @(negedge clk);
        hcfg_we = 0; ccfg_we = 0;
        moff[3] = 32'hAAAA_0000; moff[4] = 32'h1111_0000; moff[6] = 32'h2222_0000;
        rd(32'h10C0_0008, 4'h6, 8'd0, "R9 host wins same entry");
        rd(32'h1100_0008, 4'h7, 8'd0, "R9 host write other entry");
        rd(32'h1180_0008, 4'h8, 8'd0, "R9 core write other entry");

        // R8: clear and miss in the same cycle keeps the flag set
        clear_miss(1'b1);
        @(negedge clk);
        ccfg_we = 1; ccfg_addr = 6'h20;
        s_ar_valid = 1; s_ar_addr = 32'h0F00_0000; s_ar_id = 4'h9; s_ar_len = 8'd0;
        @(negedge clk);
        ccfg_we = 0; s_ar_valid = 0;
        chk(miss_flag && miss_addr == 32'h0F00_0000, "R8 miss beats clear",
            {miss_flag, miss_addr}, {1'b1, 32'h0F00_0000});
        repeat (4) @(negedge clk);

        // R11: downstream read beats reach upstream unchanged
        m_r_valid = 1; m_r_data = 32'hDEAD_BEEF; m_r_resp = 2'b00; m_r_id = 4'hA; m_r_last = 1;
        #1;
        chk(s_r_valid && s_r_data == 32'hDEAD_BEEF && s_r_id == 4'hA && s_r_last && s_r_resp == 2'b00,
            "R11 read data pass", {s_r_valid, s_r_id, s_r_data}, {1'b1, 4'hA, 32'hDEAD_BEEF});
        @(negedge clk);
        m_r_valid = 0; m_r_last = 0;

        // R1: back-pressure holds the translated request
        m_ar_ready = 0;
        @(negedge clk);
        s_ar_valid = 1; s_ar_addr = 32'h1040_0100; s_ar_id = 4'hB; s_ar_len = 8'd0;
        @(negedge clk);
        s_ar_valid = 0;
        repeat (2) @(negedge clk);
        chk(m_ar_valid && m_ar_addr == 32'h4444_0100, "R1 held under back-pressure",
            {m_ar_valid, m_ar_addr}, {1'b1, 32'h4444_0100});
        m_ar_ready = 1;
        @(negedge clk);
        chk(!m_ar_valid, "R1 released", m_ar_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule